// File: doc/BRIEF.md
# NAND Subpage ECC Transfer Sequencer

This block moves one flash subpage at a time between a host-side word buffer port and a byte-wide NAND data bus. A subpage is 528 bytes on the flash: 512 data bytes, then 16 spare bytes. Of the spare bytes only the first 6 belong to the user. The remaining 10 are check bytes that the block fills in itself. A page holds page_size/512 subpages. Software runs the sequence once for each subpage.

To write, the host pulses the encode-start trigger, which clears the check-byte accumulators. It then pushes 518 bytes through the buffer port: 129 words of 32 bits, then one 16-bit half. Finally it pulses the auto-encode trigger. The block streams the 518 buffered bytes and 10 check bytes onto the bus, one byte per cycle, and raises controller-ready when the stream ends.

To read, the host pulses the auto-decode trigger. The block accepts 528 bytes from the bus into the buffer and latches the decode result that an external corrector supplies. It then raises controller-ready, and the host drains the buffer as 132 words.

The correcting arithmetic is not part of this block. The check bytes come from a stand-in column parity. The decode status comes from input pins: a failure flag, an errors-found flag, and a 2-bit field that holds the corrected symbol count minus one. Correction strength is up to 4 symbols per subpage.

If several triggers arrive in the same cycle, only one is taken, in this priority: encode-start, then auto-encode, then auto-decode. A host write takes priority over a host read.

Top module: `nsq_seq`

## Requirements
- R1: After an accepted auto-encode, nd_out_valid is high for exactly 528 consecutive cycles, starting the cycle after the trigger. During that run nd_out_byte carries buffer offsets 0 to 517 in order, followed by the 10 check bytes.
- R2: An accepted encode-start clears all 10 check accumulators, drops ctl_ready and returns the buffer pointer to offset 0. It starts no bus activity.
- R3: A host write with hst_wide=1 stores hst_wdata as 4 bytes, bits 7:0 at the pointer and each higher byte at the next offset, and advances the pointer by 4. With hst_wide=0 it stores bits 15:0 as 2 bytes and advances the pointer by 2. The pointer may sit at any offset, and it wraps from 527 to 0 (modulo 528).
- R4: Check byte k (0 to 9) is sent at spare offset 6+k, which is subpage offset 518+k. Its value is the accumulator for column k XORed with every byte sent at offsets j<518 where j mod 10 = k. The accumulators are cleared only by encode-start, so a second emission without encode-start sends the XOR of both passes.
- R5: After an accepted auto-decode, nd_in_req is high from the next cycle until the 528th byte is accepted. A byte is accepted in a cycle where nd_in_valid is high, and accepted byte n is stored at buffer offset n.
- R6: hst_rdata shows the 4 buffer bytes starting at the pointer, with the byte at the pointer in bits 7:0. A host read advances the pointer by 4, and the pointer wraps to 0 after offset 527.
- R7: ctl_ready is 1 out of reset. It falls in the cycle after any accepted trigger. It rises exactly once per operation, in the cycle after the last byte of an emission or a fill, and it is low whenever the bus is busy.
- R8: stat_fail, stat_err and stat_corr are loaded from dec_fail, dec_err and dec_corr in the cycle the last fill byte is accepted. They change at no other time. stat_corr holds the corrected symbol count minus one, so values 0 to 3 mean 1 to 4 symbols.
- R9: While the block is emitting or filling, all three triggers and all host reads and writes are ignored.
- R10: After reset the block is idle. The pointer is 0, ctl_ready is 1, both bus strobes are low and the status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trg_enc_start | input | 1 | Encode-start trigger pulse |
| trg_auto_enc | input | 1 | Auto-encode trigger pulse |
| trg_auto_dec | input | 1 | Auto-decode trigger pulse |
| hst_wr | input | 1 | Host buffer write strobe |
| hst_wide | input | 1 | Write width: 1 selects 32 bits, 0 selects 16 bits |
| hst_wdata | input | 32 | Host write data, little-endian |
| hst_rd | input | 1 | Host buffer read strobe |
| hst_rdata | output | 32 | Buffer word at the pointer |
| nd_out_valid | output | 1 | Outgoing bus byte is valid |
| nd_out_byte | output | 8 | Outgoing bus byte |
| nd_in_req | output | 1 | Block is waiting for incoming bytes |
| nd_in_valid | input | 1 | Incoming bus byte is valid |
| nd_in_byte | input | 8 | Incoming bus byte |
| dec_fail | input | 1 | Decode result: uncorrectable |
| dec_err | input | 1 | Decode result: errors found |
| dec_corr | input | 2 | Decode result: corrected symbols minus one |
| ctl_ready | output | 1 | Controller-ready flag |
| stat_fail | output | 1 | Latched decode failure |
| stat_err | output | 1 | Latched errors-found flag |
| stat_corr | output | 2 | Latched corrected count minus one |

## Verification
Each trigger takes effect at the clock edge that samples it.
- After auto-encode, byte 0 appears on the bus one cycle later. Byte 527 appears 528 cycles later, and ctl_ready returns in the cycle after that.
- After auto-decode, nd_in_req is high one cycle later.
- ctl_ready rises in the same cycle the latched status changes, which is the cycle after the final byte is accepted.
- hst_rdata reflects a pointer move one cycle after the strobe.

The bench drives inputs on falling edges and updates its behavioural model 1 ns after each rising edge. It compares every output 3 ns after that edge. Each expected value therefore lines up with the registered cycle counted above.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_FILL = 2'd2
    } nsq_state_e;
endpackage

// File: rtl/nsq_store.sv
// Byte-organised subpage buffer: one multi-lane write port, one word read
// port for the host and one byte read port for the sequencer.
module nsq_store #(
    parameter int DEPTH = 528,
    parameter int AW    = 10,
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [LANES-1:0]   wr_mask,
    input  logic [8*LANES-1:0] wr_data,
    input  logic [AW-1:0]      hrd_addr,
    output logic [8*LANES-1:0] hrd_word,
    input  logic [AW-1:0]      srd_addr,
    output logic [7:0]         srd_byte
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wlane [LANES];
    logic [AW-1:0] rlane [LANES];

    function automatic logic [AW-1:0] wrap_off(input logic [AW-1:0] base, input int off);
        logic [AW:0] s;
        s = {1'b0, base} + (AW+1)'(off);
        if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
        return s[AW-1:0];
    endfunction

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wlane[g] = wrap_off(wr_addr, g);
        assign rlane[g] = wrap_off(hrd_addr, g);
        assign hrd_word[8*g +: 8] = mem[rlane[g]];
    end

    assign srd_byte = mem[srd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_mask[k]) mem[wlane[k]] <= wr_data[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/nsq_parity.sv
// Stand-in check-byte generator: N column accumulators fed round-robin.
module nsq_parity #(
    parameter int N  = 10,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          rewind,
    input  logic          acc_en,
    input  logic [7:0]    acc_byte,
    input  logic [IW-1:0] sel,
    output logic [7:0]    par_byte
);
    typedef struct packed {
        logic [N-1:0][7:0] cols;
        logic [IW-1:0]     slot;
    } par_t;

    par_t par_d, par_q;

    always_comb begin
        par_d = par_q;
        if (clear) begin
            par_d.cols = '0;
            par_d.slot = '0;
        end else if (rewind) begin
            par_d.slot = '0;
        end else if (acc_en) begin
            par_d.cols[par_q.slot] = par_q.cols[par_q.slot] ^ acc_byte;
            par_d.slot = (par_q.slot == IW'(N-1)) ? '0 : par_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= '0;
        else        par_q <= par_d;
    end

    assign par_byte = ({1'b0, sel} < (IW+1)'(N)) ? par_q.cols[sel] : 8'd0;
endmodule

// File: rtl/nsq_seq.sv
module nsq_seq
    import nsq_pkg::*;
#(
    parameter int DATA_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int USER_BYTES  = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trg_enc_start,
    input  logic        trg_auto_enc,
    input  logic        trg_auto_dec,
    input  logic        hst_wr,
    input  logic        hst_wide,
    input  logic [31:0] hst_wdata,
    input  logic        hst_rd,
    output logic [31:0] hst_rdata,
    output logic        nd_out_valid,
    output logic [7:0]  nd_out_byte,
    output logic        nd_in_req,
    input  logic        nd_in_valid,
    input  logic [7:0]  nd_in_byte,
    input  logic        dec_fail,
    input  logic        dec_err,
    input  logic [1:0]  dec_corr,
    output logic        ctl_ready,
    output logic        stat_fail,
    output logic        stat_err,
    output logic [1:0]  stat_corr
);
    localparam int SUB_BYTES  = DATA_BYTES + SPARE_BYTES;
    localparam int PROT_BYTES = DATA_BYTES + USER_BYTES;
    localparam int PAR_BYTES  = SPARE_BYTES - USER_BYTES;
    localparam int AW         = $clog2(SUB_BYTES);
    localparam int PW         = $clog2(PAR_BYTES);
    localparam int LANES      = 4;
    localparam logic [AW-1:0] LAST = AW'(SUB_BYTES - 1);

    typedef struct packed {
        nsq_state_e    state;
        logic [AW-1:0] cnt;
        logic [AW-1:0] ptr;
        logic          ready;
        logic          s_fail;
        logic          s_err;
        logic [1:0]    s_corr;
    } ctl_t;

    ctl_t q, d;

    logic             st_we;
    logic [AW-1:0]    st_waddr;
    logic [LANES-1:0] st_mask;
    logic [31:0]      st_wdata;
    logic [7:0]       srd_byte;
    logic [7:0]       par_byte;
    logic             par_clr, par_rew, par_acc;
    logic [PW-1:0]    par_sel;
    logic             in_prot;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input int n);
        logic [AW:0] s;
        s = {1'b0, p} + (AW+1)'(n);
        if (s >= (AW+1)'(SUB_BYTES)) s = s - (AW+1)'(SUB_BYTES);
        return s[AW-1:0];
    endfunction

    assign in_prot = (q.cnt < AW'(PROT_BYTES));

    always_comb begin
        d        = q;
        st_we    = 1'b0;
        st_waddr = q.ptr;
        st_mask  = '0;
        st_wdata = hst_wdata;
        par_clr  = 1'b0;
        par_rew  = 1'b0;
        par_acc  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (trg_enc_start) begin
                    d.ptr   = '0;
                    d.ready = 1'b0;
                    par_clr = 1'b1;
                end else if (trg_auto_enc) begin
                    d.state = ST_EMIT;
                    d.cnt   = '0;
                    d.ptr   = '0;
                    d.ready = 1'b0;
                    par_rew = 1'b1;
                end else if (trg_auto_dec) begin
                    d.state = ST_FILL;
                    d.cnt   = '0;
                    d.ptr   = '0;
                    d.ready = 1'b0;
                end else if (hst_wr) begin
                    st_we   = 1'b1;
                    st_mask = hst_wide ? 4'hF : 4'h3;
                    d.ptr   = step(q.ptr, hst_wide ? 4 : 2);
                end else if (hst_rd) begin
                    d.ptr   = step(q.ptr, 4);
                end
            end
            ST_EMIT: begin
                par_acc = in_prot;
                if (q.cnt == LAST) begin
                    d.state = ST_IDLE;
                    d.ready = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_FILL: begin
                if (nd_in_valid) begin
                    st_we    = 1'b1;
                    st_waddr = q.cnt;
                    st_mask  = 4'h1;
                    st_wdata = {24'd0, nd_in_byte};
                    if (q.cnt == LAST) begin
                        d.state  = ST_IDLE;
                        d.ready  = 1'b1;
                        d.s_fail = dec_fail;
                        d.s_err  = dec_err;
                        d.s_corr = dec_corr;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.ready <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign par_sel = PW'(q.cnt - AW'(PROT_BYTES));

    nsq_store #(.DEPTH(SUB_BYTES), .AW(AW), .LANES(LANES)) u_store (
        .clk      (clk),
        .wr_en    (st_we),
        .wr_addr  (st_waddr),
        .wr_mask  (st_mask),
        .wr_data  (st_wdata),
        .hrd_addr (q.ptr),
        .hrd_word (hst_rdata),
        .srd_addr (q.cnt),
        .srd_byte (srd_byte)
    );

    nsq_parity #(.N(PAR_BYTES), .IW(PW)) u_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (par_clr),
        .rewind   (par_rew),
        .acc_en   (par_acc),
        .acc_byte (srd_byte),
        .sel      (par_sel),
        .par_byte (par_byte)
    );

    assign nd_out_valid = (q.state == ST_EMIT);
    assign nd_out_byte  = in_prot ? srd_byte : par_byte;
    assign nd_in_req    = (q.state == ST_FILL);
    assign ctl_ready    = q.ready;
    assign stat_fail    = q.s_fail;
    assign stat_err     = q.s_err;
    assign stat_corr    = q.s_corr;
endmodule

// File: rtl/nsq_seq_chk.sv
module nsq_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trg_enc_start,
    input logic       trg_auto_enc,
    input logic       trg_auto_dec,
    input logic       nd_out_valid,
    input logic       nd_in_req,
    input logic       nd_in_valid,
    input logic       ctl_ready,
    input logic       stat_fail,
    input logic       stat_err,
    input logic [1:0] stat_corr
);
    logic busy;
    logic any_trg;
    assign busy    = nd_out_valid || nd_in_req;
    assign any_trg = trg_enc_start || trg_auto_enc || trg_auto_dec;

    p_one_direction_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nd_out_valid && nd_in_req));

    p_trigger_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (any_trg && !busy) |=> !ctl_ready);

    p_ready_low_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ctl_ready);

    p_ready_rise_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_ready) |-> $past(nd_out_valid || (nd_in_req && nd_in_valid)));

    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({stat_fail, stat_err, stat_corr}) |-> $rose(ctl_ready));

    p_dec_ignored_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_out_valid && trg_auto_dec) |=> !nd_in_req);
endmodule

bind nsq_seq nsq_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trg_enc_start (trg_enc_start),
    .trg_auto_enc  (trg_auto_enc),
    .trg_auto_dec  (trg_auto_dec),
    .nd_out_valid  (nd_out_valid),
    .nd_in_req     (nd_in_req),
    .nd_in_valid   (nd_in_valid),
    .ctl_ready     (ctl_ready),
    .stat_fail     (stat_fail),
    .stat_err      (stat_err),
    .stat_corr     (stat_corr)
);

// File: tb/nsq_seq_test.sv
`timescale 1ns/1ps
module nsq_seq_test;
    localparam int SUB  = 528;
    localparam int PROT = 518;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trg_enc_start = 0, trg_auto_enc = 0, trg_auto_dec = 0;
    logic hst_wr = 0, hst_wide = 0, hst_rd = 0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic nd_out_valid, nd_in_req, ctl_ready, stat_fail, stat_err;
    logic [7:0] nd_out_byte;
    logic nd_in_valid = 0;
    logic [7:0] nd_in_byte = '0;
    logic dec_fail = 0, dec_err = 0;
    logic [1:0] dec_corr = '0;
    logic [1:0] stat_corr;

    always #5 clk = ~clk;

    nsq_seq uut (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mmem [SUB];
    logic [7:0] mpar [10];
    logic [7:0] exp_q [$];
    int  mptr = 0;
    bit  active = 0, m_ready = 1, m_fill = 0, rdy_pending = 0;
    logic m_sfail = 0, m_serr = 0;
    logic [1:0] m_scorr = 0;
    int  em_idx = 0;
    string data_tag = "R1";

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int j);
        return 8'((j * s + s * 13 + (j >> 3)) & 255);
    endfunction

    function automatic logic [31:0] wd(input int s, input int b);
        return {pat(s, b + 3), pat(s, b + 2), pat(s, b + 1), pat(s, b)};
    endfunction

    task automatic load_emit();
        for (int j = 0; j < PROT; j++) begin
            mpar[j % 10] = mpar[j % 10] ^ mmem[j];
            exp_q.push_back(mmem[j]);
        end
        for (int k = 0; k < 10; k++) exp_q.push_back(mpar[k]);
        em_idx = 0;
    endtask

    // Per-clock comparison against the behavioural model.
    always @(posedge clk) begin
        #3;
        if (active) begin
            if (rdy_pending) begin m_ready = 1; rdy_pending = 0; end
            chk("R7", ctl_ready, m_ready);
            chk("R1", nd_out_valid, exp_q.size() != 0);
            if (nd_out_valid && exp_q.size() != 0) begin
                chk((em_idx >= PROT) ? "R4" : data_tag, nd_out_byte, exp_q.pop_front());
                em_idx++;
                if (exp_q.size() == 0) rdy_pending = 1;
            end
            chk("R5", nd_in_req, m_fill);
            chk("R8", {stat_fail, stat_err, stat_corr}, {m_sfail, m_serr, m_scorr});
        end
    end

    // kind: 0 encode-start, 1 auto-encode, 2 auto-decode
    task automatic trig(input int kind);
        @(negedge clk);
        trg_enc_start = (kind == 0);
        trg_auto_enc  = (kind == 1);
        trg_auto_dec  = (kind == 2);
        @(posedge clk); #1;
        trg_enc_start = 0; trg_auto_enc = 0; trg_auto_dec = 0;
        m_ready = 0;
        mptr = 0;
        if (kind == 0) for (int k = 0; k < 10; k++) mpar[k] = 8'd0;
        if (kind == 1) load_emit();
        if (kind == 2) m_fill = 1;
    endtask

    task automatic raw(input bit e, input bit a, input bit dd, input bit w);
        @(negedge clk);
        trg_enc_start = e; trg_auto_enc = a; trg_auto_dec = dd;
        hst_wr = w; hst_wide = 1; hst_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        trg_enc_start = 0; trg_auto_enc = 0; trg_auto_dec = 0; hst_wr = 0;
    endtask

    task automatic hwr(input bit wide, input logic [31:0] w);
        @(negedge clk);
        hst_wr = 1; hst_wide = wide; hst_wdata = w;
        @(posedge clk); #1;
        hst_wr = 0;
        for (int k = 0; k < (wide ? 4 : 2); k++) mmem[(mptr + k) % SUB] = w[8*k +: 8];
        mptr = (mptr + (wide ? 4 : 2)) % SUB;
    endtask

    task automatic hrd(input string tag);
        logic [31:0] e;
        @(negedge clk);
        for (int k = 0; k < 4; k++) e[8*k +: 8] = mmem[(mptr + k) % SUB];
        chk(tag, hst_rdata, e);
        hst_rd = 1;
        @(posedge clk); #1;
        hst_rd = 0;
        mptr = (mptr + 4) % SUB;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(posedge clk); #4;
            n++;
        end while ((exp_q.size() != 0 || !ctl_ready) && n < 3000);
    endtask

    task automatic fill(input int s, input logic f, input logic e, input logic [1:0] c);
        for (int j = 0; j < SUB; j++) begin
            if (j % 3 == 2) begin
                @(negedge clk);
                nd_in_valid = 0;
                if (j == 101) begin hst_wr = 1; hst_wide = 1; hst_wdata = 32'hDEAD_BEEF; end
                if (j == 200) trg_auto_enc = 1;
                if (j == 302) hst_rd = 1;
                @(posedge clk); #1;
                hst_wr = 0; trg_auto_enc = 0; hst_rd = 0;
            end
            @(negedge clk);
            nd_in_valid = 1; nd_in_byte = pat(s, j);
            if (j == SUB - 1) begin dec_fail = f; dec_err = e; dec_corr = c; end
            @(posedge clk); #1;
            nd_in_valid = 0;
            mmem[j] = pat(s, j);
            if (j == SUB - 1) begin
                m_fill = 0; m_ready = 1;
                m_sfail = f; m_serr = e; m_scorr = c;
                dec_fail = 0; dec_err = 0; dec_corr = 0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog: actual hung expected idle");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int j = 0; j < SUB; j++) mmem[j] = 8'd0;
        for (int k = 0; k < 10; k++) mpar[k] = 8'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #3;
        // R10: reset state
        chk("R10", ctl_ready, 1);
        chk("R10", nd_out_valid, 0);
        chk("R10", nd_in_req, 0);
        chk("R10", {stat_fail, stat_err, stat_corr}, 0);
        active = 1;

        // R2 then aligned write and emission (R1, R4)
        trig(0);
        @(posedge clk); #3;
        chk("R2", ctl_ready, 0);
        chk("R2", nd_out_valid, 0);
        for (int i = 0; i < 129; i++) hwr(1, wd(3, 4 * i));
        hwr(0, {16'd0, pat(3, 517), pat(3, 516)});
        data_tag = "R1";
        trig(1);
        wait_idle();
        chk("R7", ctl_ready, 1);

        // R4/R9: repeat without encode-start, with ignored stimulus while busy
        data_tag = "R9";
        trig(1);
        repeat (10) @(posedge clk);
        raw(1, 0, 1, 1);
        raw(0, 1, 0, 0);
        wait_idle();
        trig(1);
        wait_idle();

        // R3: unaligned word writes after a half
        trig(0);
        hwr(0, {16'd0, pat(5, 1), pat(5, 0)});
        for (int i = 0; i < 129; i++) hwr(1, wd(5, 2 + 4 * i));
        data_tag = "R3";
        trig(1);
        wait_idle();

        // R3: pointer wraps after 528 bytes
        trig(0);
        for (int i = 0; i < 132; i++) hwr(1, wd(7, 4 * i));
        hwr(1, 32'hA5A5_5A5A);
        trig(1);
        wait_idle();

        // R5/R8/R6: fill, status, drain, wrap
        trig(2);
        fill(9, 1'b0, 1'b1, 2'd2);
        wait_idle();
        chk("R8", stat_err, 1);
        chk("R8", stat_corr, 2);
        chk("R8", stat_fail, 0);
        hrd("R5");
        for (int i = 1; i < 132; i++) hrd("R6");
        hrd("R6");

        trig(2);
        fill(11, 1'b1, 1'b0, 2'd0);
        wait_idle();
        chk("R8", stat_fail, 1);
        chk("R8", {stat_err, stat_corr}, 0);
        hrd("R5");
        hrd("R9");

        repeat (3) @(posedge clk);
        #4;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule